// File: doc/BRIEF.md
# Floating-Point Compare Condition-Code Unit

This block compares two IEEE-754 operands, both single precision or both double precision, and turns the result into a 2-bit condition code. The code is written into a two-bit field of a floating-point status word. Every other bit of that word passes through unchanged. A 9-bit operation code picks the precision. It also picks between a quiet compare, which reports NaN operands as unordered, and a signalling compare, which traps on them. An operation code that is not one of the four compare codes is flagged as illegal.

The caller presents both operands, the operation code and the current status word, then pulses `start` for one cycle. On the next clock edge the unit registers its results: the condition code, the updated status word, a `done` pulse, and, when needed, a one-cycle trap or illegal flag. The ordering is worked out from the sign bit and the exponent-and-fraction magnitude alone, so no subtractor is needed.

Top module: `fp_cmp_cc`

## Requirements
- R1: While reset is held, and in the first cycle after it, `fcc`, `status_out`, `done`, `exc` and `illegal` are all zero.
- R2: A `start` pulse sampled at a rising edge updates the outputs at that same edge, and `done` is high for exactly that one following cycle.
- R3: The condition code encodes the result as 0 when equal, 1 when operand A is less than operand B, 2 when A is greater than B, and 3 when the operands are unordered.
- R4: An `opf` of 0x51 (quiet) or 0x55 (signalling) compares single-precision values taken from bits 31:0. An `opf` of 0x52 (quiet) or 0x56 (signalling) compares double-precision values using all 64 bits.
- R5: A quiet compare where either operand is a NaN (exponent all ones, fraction not zero) produces code 3 and writes it.
- R6: A signalling compare where either operand is a NaN raises `exc` for one cycle. `status_out` then equals `status_in` unchanged, and `fcc` keeps its previous value.
- R7: A signalling compare of non-NaN operands writes its code exactly as the quiet compare would.
- R8: After a written compare, `status_out[11:10]` holds the code and every other bit equals `status_in`.
- R9: Any other `opf` value raises `illegal` for one cycle. `status_out` then equals `status_in` unchanged, and `fcc` keeps its previous value.
- R10: Positive zero and negative zero compare equal.
- R11: Ordering follows sign and magnitude. Any negative value is less than any positive value, a larger magnitude is smaller when both operands are negative, and the infinities order at the two ends.
- R12: In single-precision mode, bits 63:32 of the operands have no effect on the result.
- R13: Without `start`, `fcc` and `status_out` hold their values and `done` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to compare |
| opf | input | 9 | Operation code selecting precision and quiet/signalling |
| op_a | input | 64 | First operand (single uses bits 31:0) |
| op_b | input | 64 | Second operand (single uses bits 31:0) |
| status_in | input | 32 | Current floating-point status word |
| fcc | output | 2 | Registered condition code |
| status_out | output | 32 | Registered status word with code inserted at 11:10 |
| done | output | 1 | Result valid, one cycle after start |
| exc | output | 1 | Signalling compare met a NaN |
| illegal | output | 1 | Operation code not a compare |

## Verification
Single-precision pairs cover equal, less, greater, two negatives, a positive/negative zero pair, the two infinities and a quiet NaN. Together these separate the four code values and show that sign handling reverses the magnitude order. Some single-precision pairs carry junk in their upper halves. Some double-precision pairs differ only in the low fraction bit of the upper word, which shows which bits each precision reads. Signalling compares with both ordered and NaN operands, an unknown operation code, and a status word of all ones show when the field is written and when the word is passed through untouched.

// File: rtl/fp_cmp_cc_pkg.sv
package fp_cmp_cc_pkg;
   typedef enum logic [1:0] {
      FCC_EQ = 2'd0,
      FCC_LT = 2'd1,
      FCC_GT = 2'd2,
      FCC_UN = 2'd3
   } fcc_e;

   localparam logic [8:0] OPF_SGL_QUIET = 9'h051;
   localparam logic [8:0] OPF_DBL_QUIET = 9'h052;
   localparam logic [8:0] OPF_SGL_SIGNAL = 9'h055;
   localparam logic [8:0] OPF_DBL_SIGNAL = 9'h056;
endpackage

// File: rtl/fp_cmp_decode.sv
module fp_cmp_decode
   import fp_cmp_cc_pkg::*;
(
   input  logic [8:0] opf,
   output logic       legal,
   output logic       is_dbl,
   output logic       is_sig
);
   always_comb begin
      legal  = 1'b1;
      is_dbl = 1'b0;
      is_sig = 1'b0;
      unique case (opf)
         OPF_SGL_QUIET:  ;
         OPF_DBL_QUIET:  is_dbl = 1'b1;
         OPF_SGL_SIGNAL: is_sig = 1'b1;
         OPF_DBL_SIGNAL: begin
            is_dbl = 1'b1;
            is_sig = 1'b1;
         end
         default: legal = 1'b0;
      endcase
   end

   always_comb begin
      if (!legal) assert (!is_dbl && !is_sig) else $error("p_decode_clean_r9");
   end
endmodule

// File: rtl/fp_cmp_order.sv
module fp_cmp_order
   import fp_cmp_cc_pkg::*;
#(
   parameter int EXP_W  = 8,
   parameter int FRAC_W = 23
) (
   input  logic [EXP_W+FRAC_W:0] val_a,
   input  logic [EXP_W+FRAC_W:0] val_b,
   output logic                  any_nan,
   output fcc_e                  code
);
   localparam int W     = 1 + EXP_W + FRAC_W;
   localparam int MAG_W = W - 1;

   logic             sgn_a, sgn_b;
   logic [MAG_W-1:0] mag_a, mag_b;
   logic             nan_a, nan_b, zeros, mag_lt, mag_eq;

   assign sgn_a  = val_a[W-1];
   assign sgn_b  = val_b[W-1];
   assign mag_a  = val_a[MAG_W-1:0];
   assign mag_b  = val_b[MAG_W-1:0];
   assign nan_a  = (&val_a[W-2:FRAC_W]) && (|val_a[FRAC_W-1:0]);
   assign nan_b  = (&val_b[W-2:FRAC_W]) && (|val_b[FRAC_W-1:0]);
   assign zeros  = ~|mag_a && ~|mag_b;
   assign mag_lt = mag_a < mag_b;
   assign mag_eq = mag_a == mag_b;
   assign any_nan = nan_a | nan_b;

   always_comb begin
      if (any_nan)                          code = FCC_UN;
      else if (zeros || (sgn_a == sgn_b && mag_eq)) code = FCC_EQ;
      else if (sgn_a != sgn_b)              code = sgn_a ? FCC_LT : FCC_GT;
      else if (mag_lt ^ sgn_a)              code = FCC_LT;
      else                                  code = FCC_GT;
   end
endmodule

// File: rtl/fp_cmp_cc.sv
module fp_cmp_cc
   import fp_cmp_cc_pkg::*;
#(
   parameter int SGL_EXP_W  = 8,
   parameter int SGL_FRAC_W = 23,
   parameter int DBL_EXP_W  = 11,
   parameter int DBL_FRAC_W = 52,
   parameter int STAT_W     = 32,
   parameter int FCC_LSB    = 10
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic [8:0]          opf,
   input  logic [63:0]         op_a,
   input  logic [63:0]         op_b,
   input  logic [STAT_W-1:0]   status_in,
   output logic [1:0]          fcc,
   output logic [STAT_W-1:0]   status_out,
   output logic                done,
   output logic                exc,
   output logic                illegal
);
   localparam int SGL_W = 1 + SGL_EXP_W + SGL_FRAC_W;
   localparam int DBL_W = 1 + DBL_EXP_W + DBL_FRAC_W;
   localparam logic [STAT_W-1:0] FIELD_MASK = {{(STAT_W-2){1'b0}}, 2'b11} << FCC_LSB;

   generate
      if (DBL_W != 64) begin : g_bad_dbl
         $error("double operand width must be 64");
      end
      if (SGL_W > DBL_W) begin : g_bad_sgl
         $error("single operand wider than double");
      end
      if (FCC_LSB + 2 > STAT_W) begin : g_bad_field
         $error("condition field outside status word");
      end
   endgenerate

   logic legal, is_dbl, is_sig;
   logic nan_s, nan_d, nan_sel;
   fcc_e code_s, code_d, code_sel;

   fp_cmp_decode u_dec (
      .opf    (opf),
      .legal  (legal),
      .is_dbl (is_dbl),
      .is_sig (is_sig)
   );

   fp_cmp_order #(.EXP_W(SGL_EXP_W), .FRAC_W(SGL_FRAC_W)) u_sgl (
      .val_a   (op_a[SGL_W-1:0]),
      .val_b   (op_b[SGL_W-1:0]),
      .any_nan (nan_s),
      .code    (code_s)
   );

   fp_cmp_order #(.EXP_W(DBL_EXP_W), .FRAC_W(DBL_FRAC_W)) u_dbl (
      .val_a   (op_a),
      .val_b   (op_b),
      .any_nan (nan_d),
      .code    (code_d)
   );

   assign nan_sel  = is_dbl ? nan_d : nan_s;
   assign code_sel = is_dbl ? code_d : code_s;

   logic [1:0]        fcc_q;
   logic [STAT_W-1:0] stat_q;
   logic              done_q, exc_q, ill_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fcc_q  <= '0;
         stat_q <= '0;
         done_q <= 1'b0;
         exc_q  <= 1'b0;
         ill_q  <= 1'b0;
      end else begin
         done_q <= start;
         exc_q  <= 1'b0;
         ill_q  <= 1'b0;
         if (start) begin
            if (!legal) begin
               ill_q  <= 1'b1;
               stat_q <= status_in;
            end else if (is_sig && nan_sel) begin
               exc_q  <= 1'b1;
               stat_q <= status_in;
            end else begin
               fcc_q  <= code_sel;
               stat_q <= (status_in & ~FIELD_MASK)
                         | ({{(STAT_W-2){1'b0}}, code_sel} << FCC_LSB);
            end
         end
      end
   end

   assign fcc        = fcc_q;
   assign status_out = stat_q;
   assign done       = done_q;
   assign exc        = exc_q;
   assign illegal    = ill_q;

   p_done_after_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(start));
   p_other_bits_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (((status_out ^ $past(status_in)) & ~FIELD_MASK) == '0));
   p_trap_keeps_word_r6: assert property (@(posedge clk) disable iff (!rst_n)
      exc |-> (status_out == $past(status_in)) && $stable(fcc));
   p_illegal_keeps_word_r9: assert property (@(posedge clk) disable iff (!rst_n)
      illegal |-> (status_out == $past(status_in)) && $stable(fcc));
   p_flags_exclusive_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(exc && illegal));
   p_flags_need_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (exc || illegal) |-> done);
   p_idle_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
      !start |=> $stable(status_out) && $stable(fcc) && !done);
endmodule

// File: tb/fp_cmp_cc_tb.sv
module fp_cmp_cc_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int MAX_CYCLES = 5000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [8:0]  opf = '0;
   logic [63:0] op_a = '0;
   logic [63:0] op_b = '0;
   logic [31:0] status_in = '0;
   logic [1:0]  fcc;
   logic [31:0] status_out;
   logic        done, exc, illegal;

   int checks = 0;
   int errors = 0;
   logic [1:0] last_fcc = 2'd0;

   always #(CLK_PERIOD/2) clk = ~clk;

   fp_cmp_cc dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .opf(opf),
      .op_a(op_a), .op_b(op_b), .status_in(status_in),
      .fcc(fcc), .status_out(status_out), .done(done),
      .exc(exc), .illegal(illegal)
   );

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] merged(input logic [31:0] s, input logic [1:0] c);
      return (s & ~(32'h3 << 10)) | ({30'd0, c} << 10);
   endfunction

   task automatic issue(input logic [8:0] o, input logic [63:0] a, input logic [63:0] b,
                        input logic [31:0] s);
      @(negedge clk);
      opf = o; op_a = a; op_b = b; status_in = s; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   // compare that must write its code
   task automatic t_write(input string tag, input logic [8:0] o, input logic [63:0] a,
                          input logic [63:0] b, input logic [31:0] s, input logic [1:0] exp_c);
      issue(o, a, b, s);
      check({tag, " R2 done"}, done, 1);
      check({tag, " R3 fcc"}, fcc, exp_c);
      check({tag, " R8 word"}, status_out, merged(s, exp_c));
      check({tag, " R6 no trap"}, {exc, illegal}, 0);
      last_fcc = exp_c;
   endtask

   task automatic t_reset;
      check("R1 reset fcc", fcc, 0);
      check("R1 reset word", status_out, 0);
      check("R1 reset flags", {done, exc, illegal}, 0);
   endtask

   task automatic t_single;
      t_write("R3 sgl lt", 9'h051, 64'h3F800000, 64'h40000000, 32'h0, 2'd1);
      t_write("R3 sgl gt", 9'h051, 64'h40000000, 64'h3F800000, 32'h0, 2'd2);
      t_write("R3 sgl eq", 9'h051, 64'h3F800000, 64'h3F800000, 32'h5A5A5A5A, 2'd0);
      t_write("R11 sgl neg", 9'h051, 64'hBF800000, 64'hC0000000, 32'h0, 2'd2);
      t_write("R11 sgl mixed", 9'h051, 64'hBF800000, 64'h00000001, 32'h0, 2'd1);
      t_write("R11 sgl inf", 9'h051, 64'hFF800000, 64'h7F800000, 32'h0, 2'd1);
      t_write("R10 zeros", 9'h051, 64'h00000000, 64'h80000000, 32'h0, 2'd0);
      t_write("R5 sgl nan", 9'h051, 64'h7FC00000, 64'h3F800000, 32'h0, 2'd3);
      t_write("R12 upper junk", 9'h051, 64'hDEADBEEF_3F800000, 64'h12345678_3F800000,
              32'h0, 2'd0);
   endtask

   task automatic t_double;
      t_write("R4 dbl lt", 9'h052, 64'h3FF0000000000000, 64'h4000000000000000, 32'h0, 2'd1);
      t_write("R4 dbl upper lsb", 9'h052, 64'h3FF0000100000000, 64'h3FF0000000000000,
              32'h0, 2'd2);
      t_write("R11 dbl neg", 9'h052, 64'hBFF8000000000000, 64'h3FF0000000000000, 32'h0, 2'd1);
      t_write("R5 dbl nan", 9'h052, 64'h3FF0000000000000, 64'h7FF0000000000001, 32'h0, 2'd3);
   endtask

   task automatic t_signal;
      t_write("R7 sig sgl", 9'h055, 64'h3F800000, 64'h40000000, 32'h0, 2'd1);
      t_write("R7 sig dbl", 9'h056, 64'h4000000000000000, 64'h3FF0000000000000, 32'h0, 2'd2);
      issue(9'h055, 64'h7FC00000, 64'h3F800000, 32'hCAFE0C00);
      check("R6 sgl trap", exc, 1);
      check("R6 sgl word", status_out, 32'hCAFE0C00);
      check("R6 sgl fcc hold", fcc, last_fcc);
      issue(9'h056, 64'h7FF8000000000000, 64'h0, 32'h00000000);
      check("R6 dbl trap", {exc, illegal}, 2'b10);
      check("R6 dbl word", status_out, 32'h0);
   endtask

   task automatic t_illegal;
      issue(9'h053, 64'h3F800000, 64'h40000000, 32'h13579BDF);
      check("R9 flag", {illegal, exc}, 2'b10);
      check("R9 word", status_out, 32'h13579BDF);
      check("R9 fcc hold", fcc, last_fcc);
   endtask

   task automatic t_field;
      t_write("R8 all ones", 9'h051, 64'h3F800000, 64'h3F800000, 32'hFFFFFFFF, 2'd0);
      check("R8 exact", status_out, 32'hFFFFF3FF);
   endtask

   task automatic t_idle;
      logic [31:0] held;
      logic [1:0]  hf;
      held = status_out;
      hf = fcc;
      @(negedge clk);
      status_in = 32'hA5A5A5A5; opf = 9'h051; op_a = 64'h7FC00000;
      repeat (3) @(negedge clk);
      check("R13 word hold", status_out, held);
      check("R13 fcc hold", fcc, hf);
      check("R13 done low", done, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_single();
      t_double();
      t_signal();
      t_illegal();
      t_field();
      t_idle();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (MAX_CYCLES) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule